// File: doc/BRIEF.md
# Boot-Mode Address Decoder with Remap

This block turns a 32-bit processor address into a memory select. The top four address bits pick one of sixteen 256 MB banks. Bank 0 is the internal region and holds only a ROM and an SRAM. Banks 1 to 8 drive eight external chip selects in ascending order. Banks 9 to 15 are unmapped. Each access also gets a local offset, which is the address measured from the base of the memory that answers.

The lowest 1 MB of bank 0 is a zero window, and its owner can change. A boot strap pin is captured once when reset is released. A remap bit is written by software and is cleared by reset.

| Remap | Strap | Zero window answered by |
|-------|-------|-------------------------|
| 0 | 1 | internal ROM |
| 0 | 0 | external chip select 0 |
| 1 | either | internal SRAM |

The ROM at offset 0x0010_0000 and the SRAM at offset 0x0020_0000 always decode at those fixed locations, whatever the setting.

A typical boot sequence runs in this order:
1. Start execution from the strap-chosen memory.
2. Copy the startup code into the SRAM.
3. Set the remap bit.
4. Jump to address zero.

The address path is purely combinational. It carries no valid/ready handshake and applies no back-pressure. The select is valid in the same cycle as the qualified address, and a consumer that stalls simply holds the address.

Top module: `bootmap_decoder`

## Requirements
- R1: When address bits [31:28] hold a value b from 1 to 8, the decoder asserts `sel_ext_o` bit b-1 and no other select. In this case `offset_o` equals address bits [27:0].
- R2: These addresses select nothing and give `offset_o` = 0:
  - banks 9 to 15;
  - bank 0 offsets from 0x0030_0000 upward.
- R3: Two bank 0 windows decode at fixed locations, whatever the remap or strap setting. In both, `offset_o` equals address bits [19:0].
  - Offsets 0x0010_0000 to 0x001F_FFFF select the ROM.
  - Offsets 0x0020_0000 to 0x002F_FFFF select the SRAM.
- R4: With remap 0 and a captured strap of 1, bank 0 offsets 0x0000_0000 to 0x000F_FFFF select the ROM, and `offset_o` equals address bits [19:0].
- R5: With remap 0 and a captured strap of 0, the same zero window selects `sel_ext_o` bit 0, and `offset_o` equals address bits [27:0].
- R6: With remap 1, the zero window selects the SRAM whatever the strap level.
- R7: Reset clears remap to 0. A cycle with `cfg_we_i` high loads `cfg_remap_i` into remap, and the new value steers decoding from the cycle after that clock edge.
- R8: The strap pin is captured on the first rising clock edge at which `rst_n` is high. Later changes on the pin have no effect until the next reset.
- R9: At most one select is asserted at any time. While `addr_valid_i` is low, or before the strap has been captured, every select is low and `offset_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap_i | input | 1 | Boot strap pin; 1 selects ROM boot, 0 selects external boot |
| cfg_we_i | input | 1 | Write strobe for the remap bit |
| cfg_remap_i | input | 1 | Value written to the remap bit |
| addr_i | input | 32 | Processor address |
| addr_valid_i | input | 1 | Address qualifier |
| sel_rom_o | output | 1 | Internal ROM select |
| sel_sram_o | output | 1 | Internal SRAM select |
| sel_ext_o | output | 8 | External chip selects, one-hot |
| offset_o | output | 28 | Local offset within the selected memory |

## Verification
The hardest situation to reach is a strap pin that changes after capture. Reaching it requires the pin to toggle while the decoder is running. The bench does this by flipping `boot_strap_i` after reset release and then checking that address zero still reaches the memory chosen at capture. A second reset with the opposite strap level then shows three things: remap was cleared, the new strap took effect, and the zero window moved to external chip select 0. Remap is also written back to 0 in mid-run to confirm that the zero window returns to the strap-chosen memory.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  // Memory class that the bank 0 decoder resolves to
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_SRAM = 2'd2,
    TGT_EXT0 = 2'd3
  } tgt_e;
endpackage

// File: rtl/bootmap_strap_cfg.sv
module bootmap_strap_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  input  logic we_i,
  input  logic remap_wr_i,
  output logic captured_o,
  output logic boot_rom_o,
  output logic remap_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured_o <= 1'b0;
      boot_rom_o <= 1'b0;
      remap_o    <= 1'b0;
    end else begin
      if (!captured_o) begin
        captured_o <= 1'b1;
        boot_rom_o <= strap_i;
      end
      if (we_i) remap_o <= remap_wr_i;
    end
  end

  // R8: strap level is frozen once captured
  a_r8_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    captured_o |=> $stable(boot_rom_o));
  // R7: a write lands in the remap bit on the following edge
  a_r7_remap_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (remap_o == $past(remap_wr_i)));
  // R8: capture happens exactly once after reset
  a_r8_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
    captured_o |=> captured_o);
endmodule

// File: rtl/bootmap_bank_dec.sv
module bootmap_bank_dec #(
  parameter int ADDR_W    = 32,
  parameter int BANK_W    = 4,
  parameter int EXT_N     = 8,
  parameter int EXT_FIRST = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              int_hit_o,
  output logic [EXT_N-1:0]  ext_hit_o
);
  logic [BANK_W-1:0] bank;
  assign bank      = addr_i[ADDR_W-1 -: BANK_W];
  assign int_hit_o = (bank == '0);

  for (genvar i = 0; i < EXT_N; i++) begin : g_ext
    assign ext_hit_o[i] = (bank == BANK_W'(EXT_FIRST + i));
  end
endmodule

// File: rtl/bootmap_int_dec.sv
module bootmap_int_dec
  import bootmap_pkg::*;
#(
  parameter int OFS_W     = 28,
  parameter int REGION_W  = 20,
  parameter int ROM_SLOT  = 1,
  parameter int SRAM_SLOT = 2
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             remap_i,
  input  logic             boot_rom_i,
  output tgt_e             tgt_o,
  output logic [OFS_W-1:0] loc_ofs_o
);
  localparam int SLOT_W = OFS_W - REGION_W;

  logic [SLOT_W-1:0] slot;
  assign slot = ofs_i[OFS_W-1:REGION_W];

  always_comb begin
    tgt_o = TGT_NONE;
    if (slot == '0) begin
      if (remap_i)         tgt_o = TGT_SRAM;
      else if (boot_rom_i) tgt_o = TGT_ROM;
      else                 tgt_o = TGT_EXT0;
    end else if (slot == SLOT_W'(ROM_SLOT)) begin
      tgt_o = TGT_ROM;
    end else if (slot == SLOT_W'(SRAM_SLOT)) begin
      tgt_o = TGT_SRAM;
    end
    loc_ofs_o = (tgt_o == TGT_NONE) ? '0 : OFS_W'(ofs_i[REGION_W-1:0]);
  end
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
  import bootmap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BANK_W    = 4,
  parameter int EXT_N     = 8,
  parameter int REGION_W  = 20,
  parameter int ROM_SLOT  = 1,
  parameter int SRAM_SLOT = 2,
  localparam int OFS_W    = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap_i,
  input  logic              cfg_we_i,
  input  logic              cfg_remap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_valid_i,
  output logic              sel_rom_o,
  output logic              sel_sram_o,
  output logic [EXT_N-1:0]  sel_ext_o,
  output logic [OFS_W-1:0]  offset_o
);
  logic             captured, boot_rom, remap, int_hit, live;
  logic [EXT_N-1:0] ext_hit;
  tgt_e             tgt;
  logic [OFS_W-1:0] int_ofs;

  bootmap_strap_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_i    (boot_strap_i),
    .we_i       (cfg_we_i),
    .remap_wr_i (cfg_remap_i),
    .captured_o (captured),
    .boot_rom_o (boot_rom),
    .remap_o    (remap)
  );

  bootmap_bank_dec #(
    .ADDR_W (ADDR_W), .BANK_W (BANK_W), .EXT_N (EXT_N), .EXT_FIRST (1)
  ) u_bank (
    .addr_i    (addr_i),
    .int_hit_o (int_hit),
    .ext_hit_o (ext_hit)
  );

  bootmap_int_dec #(
    .OFS_W (OFS_W), .REGION_W (REGION_W), .ROM_SLOT (ROM_SLOT), .SRAM_SLOT (SRAM_SLOT)
  ) u_int (
    .ofs_i      (addr_i[OFS_W-1:0]),
    .remap_i    (remap),
    .boot_rom_i (boot_rom),
    .tgt_o      (tgt),
    .loc_ofs_o  (int_ofs)
  );

  assign live       = addr_valid_i && captured;
  assign sel_rom_o  = live && int_hit && (tgt == TGT_ROM);
  assign sel_sram_o = live && int_hit && (tgt == TGT_SRAM);

  for (genvar i = 0; i < EXT_N; i++) begin : g_cs
    if (i == 0) begin : g_alias
      assign sel_ext_o[i] = live && (ext_hit[i] || (int_hit && tgt == TGT_EXT0));
    end else begin : g_plain
      assign sel_ext_o[i] = live && ext_hit[i];
    end
  end

  always_comb begin
    offset_o = '0;
    if (live) begin
      if (int_hit)        offset_o = int_ofs;
      else if (|ext_hit)  offset_o = addr_i[OFS_W-1:0];
    end
  end

  // R9: never more than one select
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom_o, sel_sram_o, sel_ext_o}));
  // R9: idle when unqualified
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid_i && captured) |-> ({sel_rom_o, sel_sram_o, sel_ext_o} == '0 && offset_o == '0));
  // R6: remap routes the zero window to SRAM
  a_r6_remap_sram: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_i && captured && remap && addr_i[ADDR_W-1:REGION_W] == '0) |-> sel_sram_o);
  // R1: external bank decode
  a_r1_ext_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_i && captured && addr_i[ADDR_W-1 -: BANK_W] >= BANK_W'(1)
     && addr_i[ADDR_W-1 -: BANK_W] <= BANK_W'(EXT_N))
    |-> (sel_ext_o == (EXT_N'(1) << (addr_i[ADDR_W-1 -: BANK_W] - BANK_W'(1)))));
endmodule

// File: tb/bootmap_decoder_tb.sv
module bootmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic        we = 1'b0;
  logic        wdata = 1'b0;
  logic [31:0] addr = '0;
  logic        valid = 1'b0;
  logic        rom, sram;
  logic [7:0]  ext;
  logic [27:0] ofs;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  bootmap_decoder u_dut (
    .clk (clk), .rst_n (rst_n), .boot_strap_i (strap), .cfg_we_i (we),
    .cfg_remap_i (wdata), .addr_i (addr), .addr_valid_i (valid),
    .sel_rom_o (rom), .sel_sram_o (sram), .sel_ext_o (ext), .offset_o (ofs)
  );

  task automatic check(input string req, input logic [9:0] exp_sel, input logic [27:0] exp_ofs);
    n_chk++;
    if ({rom, sram, ext} !== exp_sel || ofs !== exp_ofs) begin
      n_err++;
      $display("FAIL %s: sel=%b ofs=%h expected sel=%b ofs=%h", req, {rom, sram, ext}, ofs, exp_sel, exp_ofs);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic v, input string req,
                       input logic [9:0] exp_sel, input logic [27:0] exp_ofs);
    @(negedge clk);
    addr = a; valid = v;
    #1 check(req, exp_sel, exp_ofs);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; addr = 32'h0; valid = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R9 in reset", 10'b0, 28'h0);
    rst_n = 1'b1;
    #1 check("R9 before capture", 10'b0, 28'h0);
    @(posedge clk);
  endtask

  task automatic write_remap(input logic v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_rom_boot();
    do_reset(1'b1);
    probe(32'h0000_1234, 1'b1, "R4 zero window ROM", 10'b10_0000_0000, 28'h000_1234);
    strap = 1'b0;
    probe(32'h0000_0000, 1'b1, "R8 strap change ignored", 10'b10_0000_0000, 28'h0);
    probe(32'h0010_0040, 1'b1, "R3 fixed ROM", 10'b10_0000_0000, 28'h000_0040);
    probe(32'h0020_0008, 1'b1, "R3 fixed SRAM", 10'b01_0000_0000, 28'h000_0008);
    probe(32'h1000_0010, 1'b1, "R1 bank1 cs0", 10'b00_0000_0001, 28'h000_0010);
    probe(32'h8FFF_FFFC, 1'b1, "R1 bank8 cs7", 10'b00_1000_0000, 28'hFFF_FFFC);
    probe(32'h4000_0100, 1'b1, "R1 bank4 cs3", 10'b00_0000_1000, 28'h000_0100);
    probe(32'h9000_0000, 1'b1, "R2 bank9 none", 10'b0, 28'h0);
    probe(32'h0030_0000, 1'b1, "R2 bank0 hole", 10'b0, 28'h0);
    probe(32'h1000_0010, 1'b0, "R9 valid low", 10'b0, 28'h0);
    write_remap(1'b1);
    probe(32'h0000_0020, 1'b1, "R6 remap SRAM", 10'b01_0000_0000, 28'h000_0020);
    probe(32'h0010_0000, 1'b1, "R3 ROM with remap", 10'b10_0000_0000, 28'h0);
  endtask

  task automatic t_ext_boot();
    do_reset(1'b0);
    probe(32'h0000_0044, 1'b1, "R7 remap cleared / R5 zero window cs0", 10'b00_0000_0001, 28'h000_0044);
    probe(32'h000F_FFFF, 1'b1, "R5 zero window top", 10'b00_0000_0001, 28'h00F_FFFF);
    probe(32'h0020_0000, 1'b1, "R3 SRAM in ext boot", 10'b01_0000_0000, 28'h0);
    write_remap(1'b1);
    probe(32'h0000_0000, 1'b1, "R6 remap over strap 0", 10'b01_0000_0000, 28'h0);
    write_remap(1'b0);
    probe(32'h0000_0008, 1'b1, "R7 remap written back to 0", 10'b00_0000_0001, 28'h000_0008);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_rom_boot();
    t_ext_boot();
    finish_run();
  end
endmodule